// File: doc/BRIEF.md
# Cascade Slave Interrupt Vector Responder

This block is the slave half of a two-level interrupt arrangement. It watches eight level-sensitive request lines and raises one request output that is wired to a single input of a master controller. When the processor runs its two-pulse acknowledge sequence, the master puts a 3-bit cascade address on a shared bus. Every slave on that bus compares the address with its own programmed identity. Only the slave whose identity matches takes part in the sequence. It admits its best pending line to service on the first pulse and places an 8-bit vector on the data bus during the second pulse.

The vector is formed from a 5-bit programmable base in the upper bits and the 3-bit line number in the lower bits. The block keeps its own in-service set. Each line in that set masks requests of equal or lower priority until software sends the slave an end-of-interrupt pulse, which it does after the master's own end-of-interrupt. Line 0 has the highest priority. An identity of zero is legal but hazardous: it also matches acknowledges for the master's own uncascaded inputs, which leave the address at zero. The block flags every vector it drives under identity zero so that bus contention can be seen.

The acknowledge strobe is active low and is sampled on the block clock. Each edge of the strobe takes effect on the first clock at which the new level is sampled.

Top module: `cas_slave_responder`

## Requirements
- R1: After reset, int_out, vec_oe, vec_out and id0_conflict are all 0 and no line is in service.
- R2: Outside a matched acknowledge window, int_out is 1 exactly when some request line has a lower index than every in-service line (any request when nothing is in service).
- R3: On the first sampled falling edge of ack_n, if cas_in equals cfg_id, the lowest-index request line satisfying R2 enters service. If cas_in and cfg_id differ, the in-service set is unchanged.
- R4: On the clock that samples the second falling edge of a matched sequence, vec_oe becomes 1 and vec_out becomes {cfg_base, line}, with cfg_base in bits 7:3 and the 3-bit line number from R3 in bits 2:0.
- R5: In a sequence whose cas_in did not match cfg_id at the first falling edge, vec_oe stays 0 and vec_out stays 0.
- R6: vec_oe returns to 0, and vec_out to 0, on the clock that samples ack_n high after the second pulse.
- R7: int_out is held at 1 from the matched first falling edge until the second falling edge. After that it follows R2 again.
- R8: With cfg_id = 0 and cas_in = 0 the block drives its vector, and id0_conflict is 1 on exactly the clocks on which it drives a vector under identity 0.
- R9: A one-clock eoi pulse removes the lowest-index in-service line, so that a request of that priority or lower can raise int_out again.
- R10: If no line satisfies R2 at a matched first falling edge, the vector line number is 7 and the in-service set is unchanged.
- R11: cfg_id and cas_in are compared only at the first falling edge. Changing them later in the sequence does not alter whether the vector is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_in | input | 8 | Level interrupt requests, line 0 highest priority |
| cfg_id | input | 3 | Programmed slave identity |
| cfg_base | input | 5 | Upper five bits of the vector |
| cas_in | input | 3 | Cascade address from the master |
| ack_n | input | 1 | Shared acknowledge strobe, active low |
| eoi | input | 1 | One-clock end-of-interrupt command for this slave |
| int_out | output | 1 | Request to the master input |
| vec_out | output | 8 | Vector data, zero when not enabled |
| vec_oe | output | 1 | Data-bus drive enable |
| id0_conflict | output | 1 | Vector being driven under identity zero |

## Verification
A wrong in-service set has two visible effects. It changes int_out on the very next clock, and it changes the line number in the next matched vector. A match result that was latched wrongly or never cleared shows up as vec_oe high, or missing, on the clock after the second falling edge, or as vec_oe still high one clock after the strobe rises. A non-matching slave that changed its in-service set does not show it at once. The change appears only at the next int_out or vector comparison, and the bench makes one of those after every sequence and every eoi pulse.

// File: rtl/cas_pkg.sv
`timescale 1ns/1ps
package cas_pkg;
  localparam int NUM_LINES = 8;
  localparam int LINE_W    = $clog2(NUM_LINES);
  localparam int BASE_W    = 5;
  localparam int VEC_W     = BASE_W + LINE_W;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_P1LO = 2'd1,
    SEQ_P1HI = 2'd2,
    SEQ_P2LO = 2'd3
  } seq_state_t;
endpackage

// File: rtl/cas_ack_seq.sv
`timescale 1ns/1ps
module cas_ack_seq #(
  parameter int ID_W = cas_pkg::LINE_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ack_n,
  input  logic [ID_W-1:0] cas_in,
  input  logic [ID_W-1:0] cfg_id,
  output logic            first_fall,
  output logic            second_fall,
  output logic            seq_end,
  output logic            hold_win,
  output logic            match_q,
  output logic [ID_W-1:0] id_q
);
  import cas_pkg::*;

  logic       ack_q;
  logic       fall_w, rise_w;
  seq_state_t st;

  assign fall_w      = ack_q & ~ack_n;
  assign rise_w      = ~ack_q & ack_n;
  assign first_fall  = fall_w && (st == SEQ_IDLE);
  assign second_fall = fall_w && (st == SEQ_P1HI);
  assign seq_end     = rise_w && (st == SEQ_P2LO);
  assign hold_win    = match_q && ((st == SEQ_P1LO) || (st == SEQ_P1HI));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q   <= 1'b1;
      st      <= SEQ_IDLE;
      match_q <= 1'b0;
      id_q    <= '0;
    end else begin
      ack_q <= ack_n;
      unique case (st)
        SEQ_IDLE: if (fall_w) begin
          st      <= SEQ_P1LO;
          match_q <= (cas_in == cfg_id);
          id_q    <= cfg_id;
        end
        SEQ_P1LO: if (rise_w) st <= SEQ_P1HI;
        SEQ_P1HI: if (fall_w) st <= SEQ_P2LO;
        SEQ_P2LO: if (rise_w) begin
          st      <= SEQ_IDLE;
          match_q <= 1'b0;
        end
        default: st <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cas_prio_pick.sv
`timescale 1ns/1ps
module cas_prio_pick #(
  parameter int N   = cas_pkg::NUM_LINES,
  parameter int LW  = $clog2(N)
) (
  input  logic [N-1:0]  req,
  input  logic [N-1:0]  isr,
  output logic          any_above,
  output logic          found,
  output logic [LW-1:0] line
);
  // Lines strictly above the highest-priority in-service line.
  function automatic logic [N-1:0] above_mask(input logic [N-1:0] s);
    logic [N-1:0] m;
    logic         stop;
    m    = '0;
    stop = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (s[i]) stop = 1'b1;
      if (!stop) m[i] = 1'b1;
    end
    return m;
  endfunction

  logic [N-1:0] eligible;
  assign eligible  = req & above_mask(isr);
  assign any_above = |eligible;

  always_comb begin
    found = 1'b0;
    line  = LW'(N - 1);
    for (int i = N - 1; i >= 0; i--) begin
      if (eligible[i]) begin
        found = 1'b1;
        line  = LW'(i);
      end
    end
  end
endmodule

// File: rtl/cas_isr_bank.sv
`timescale 1ns/1ps
module cas_isr_bank #(
  parameter int N  = cas_pkg::NUM_LINES,
  parameter int LW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic [LW-1:0] set_line,
  input  logic          eoi,
  output logic [N-1:0]  isr
);
  function automatic logic [N-1:0] lowest_set(input logic [N-1:0] s);
    return s & (~s + 1'b1);
  endfunction

  logic [N-1:0] after_eoi;
  logic [N-1:0] set_vec;

  assign after_eoi = eoi ? (isr & ~lowest_set(isr)) : isr;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_set
      assign set_vec[g] = set_en && (set_line == LW'(g));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) isr <= '0;
    else        isr <= after_eoi | set_vec;
  end
endmodule

// File: rtl/cas_slave_responder.sv
`timescale 1ns/1ps
module cas_slave_responder #(
  parameter int N_LINES = cas_pkg::NUM_LINES,
  parameter int BASE_W  = cas_pkg::BASE_W,
  localparam int LW     = $clog2(N_LINES),
  localparam int VW     = BASE_W + LW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_LINES-1:0] req_in,
  input  logic [LW-1:0]     cfg_id,
  input  logic [BASE_W-1:0] cfg_base,
  input  logic [LW-1:0]     cas_in,
  input  logic              ack_n,
  input  logic              eoi,
  output logic              int_out,
  output logic [VW-1:0]     vec_out,
  output logic              vec_oe,
  output logic              id0_conflict
);
  logic              first_fall_w, second_fall_w, seq_end_w, hold_w, match_w;
  logic [LW-1:0]     id_w;
  logic              any_above_w, found_w;
  logic [LW-1:0]     pick_w;
  logic [N_LINES-1:0] isr_w;
  logic              set_w;
  logic [LW-1:0]     line_q;
  logic              oe_q;
  logic [VW-1:0]     vec_q;

  cas_ack_seq #(.ID_W(LW)) u_seq (
    .clk(clk), .rst_n(rst_n), .ack_n(ack_n), .cas_in(cas_in), .cfg_id(cfg_id),
    .first_fall(first_fall_w), .second_fall(second_fall_w), .seq_end(seq_end_w),
    .hold_win(hold_w), .match_q(match_w), .id_q(id_w)
  );

  cas_prio_pick #(.N(N_LINES), .LW(LW)) u_pick (
    .req(req_in), .isr(isr_w), .any_above(any_above_w),
    .found(found_w), .line(pick_w)
  );

  // Matching is evaluated on the same edge the sequencer latches it.
  assign set_w = first_fall_w && (cas_in == cfg_id) && found_w;

  cas_isr_bank #(.N(N_LINES), .LW(LW)) u_isr (
    .clk(clk), .rst_n(rst_n), .set_en(set_w), .set_line(pick_w),
    .eoi(eoi), .isr(isr_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      oe_q   <= 1'b0;
      vec_q  <= '0;
    end else begin
      if (first_fall_w) line_q <= pick_w;
      if (second_fall_w && match_w) begin
        oe_q  <= 1'b1;
        vec_q <= {cfg_base, line_q};
      end else if (seq_end_w) begin
        oe_q  <= 1'b0;
        vec_q <= '0;
      end
    end
  end

  assign int_out      = hold_w | any_above_w;
  assign vec_oe       = oe_q;
  assign vec_out      = vec_q;
  assign id0_conflict = oe_q && (id_w == '0);
endmodule

// File: rtl/cas_slave_chk.sv
`timescale 1ns/1ps
module cas_slave_chk #(
  parameter int N  = 8,
  parameter int LW = 3
) (
  input logic         clk,
  input logic         rst_n,
  input logic         first_fall,
  input logic         second_fall,
  input logic         seq_end,
  input logic         hold_win,
  input logic         match_q,
  input logic         set_en,
  input logic         eoi,
  input logic [N-1:0] isr,
  input logic         int_out,
  input logic         vec_oe,
  input logic         id0_conflict
);
  assert_isr_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_en && !eoi) |=> $stable(isr));

  assert_oe_after_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vec_oe) |-> $past(second_fall));

  assert_oe_needs_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
    vec_oe |-> match_q);

  assert_oe_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    seq_end |=> !vec_oe);

  assert_hold_int_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hold_win |-> int_out);

  assert_conflict_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    id0_conflict |-> vec_oe);

  assert_eoi_one_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !set_en && (isr != '0)) |=> ($countones(isr) == $countones($past(isr)) - 1));

  assert_set_on_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |-> first_fall);
endmodule

bind cas_slave_responder cas_slave_chk #(.N(N_LINES), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .first_fall(first_fall_w), .second_fall(second_fall_w),
  .seq_end(seq_end_w), .hold_win(hold_w), .match_q(match_w), .set_en(set_w),
  .eoi(eoi), .isr(isr_w), .int_out(int_out), .vec_oe(vec_oe),
  .id0_conflict(id0_conflict)
);

// File: tb/cas_slave_responder_tb.sv
`timescale 1ns/1ps
module cas_slave_responder_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req_in = '0;
  logic [2:0] cfg_id = '0;
  logic [4:0] cfg_base = '0;
  logic [2:0] cas_in = '0;
  logic       ack_n = 1'b1;
  logic       eoi = 1'b0;
  logic       int_out, vec_oe, id0_conflict;
  logic [7:0] vec_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [7:0] m_isr = '0;

  always #4 clk = ~clk;

  cas_slave_responder u_dut (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .cfg_id(cfg_id), .cfg_base(cfg_base),
    .cas_in(cas_in), .ack_n(ack_n), .eoi(eoi), .int_out(int_out),
    .vec_out(vec_out), .vec_oe(vec_oe), .id0_conflict(id0_conflict)
  );

  function automatic logic [7:0] m_eligible(input logic [7:0] r, input logic [7:0] s);
    logic [7:0] e = '0;
    for (int i = 0; i < 8; i++) begin
      if (s[i]) break;
      e[i] = r[i];
    end
    return e;
  endfunction

  function automatic int m_first(input logic [7:0] e);
    for (int i = 0; i < 8; i++) if (e[i]) return i;
    return -1;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_idle_int(input string req);
    chk(req, {31'd0, int_out}, {31'd0, (m_eligible(req_in, m_isr) != 0)});
  endtask

  // Full acknowledge sequence; id_late/cas_late applied after the first pulse.
  task automatic ack_seq(input logic [2:0] cas, input logic [2:0] id_late,
                         input logic [2:0] cas_late);
    logic match;
    int   ln;
    logic [7:0] expv;
    logic [2:0] id_used;
    match   = (cas == cfg_id);
    id_used = cfg_id;
    ln      = m_first(m_eligible(req_in, m_isr));
    cas_in  = cas;
    ack_n   = 1'b0;
    @(negedge clk);
    if (match && ln >= 0) m_isr[ln] = 1'b1;
    if (match) chk("R7 hold first low", {31'd0, int_out}, 32'd1);
    else       chk_idle_int("R2 unmatched first low");
    chk("R5 no early drive", {31'd0, vec_oe}, 32'd0);
    cfg_id = id_late;
    cas_in = cas_late;
    ack_n  = 1'b1;
    @(negedge clk);
    if (match) chk("R7 hold between", {31'd0, int_out}, 32'd1);
    ack_n = 1'b0;
    @(negedge clk);
    expv = {cfg_base, (ln < 0) ? 3'd7 : 3'(ln)};
    if (match) begin
      chk("R4 vec_oe", {31'd0, vec_oe}, 32'd1);
      chk((ln < 0) ? "R10 spurious vector" : "R3 R4 vector", {24'd0, vec_out}, {24'd0, expv});
      chk("R8 conflict flag", {31'd0, id0_conflict}, {31'd0, id_used == 3'd0});
    end else begin
      chk("R5 no drive", {31'd0, vec_oe}, 32'd0);
      chk("R5 vec zero", {24'd0, vec_out}, 32'd0);
    end
    chk_idle_int("R7 R2 after second fall");
    ack_n = 1'b1;
    @(negedge clk);
    chk("R6 float", {31'd0, vec_oe}, 32'd0);
    chk("R6 vec zero", {24'd0, vec_out}, 32'd0);
    chk("R8 conflict off", {31'd0, id0_conflict}, 32'd0);
  endtask

  task automatic pulse_eoi;
    eoi = 1'b1;
    @(negedge clk);
    eoi = 1'b0;
    m_isr = m_isr & ~(m_isr & (~m_isr + 8'd1));
    chk_idle_int("R9 eoi");
  endtask

  task automatic finish_run;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 int", {31'd0, int_out}, 32'd0);
    chk("R1 oe", {31'd0, vec_oe}, 32'd0);
    chk("R1 vec", {24'd0, vec_out}, 32'd0);
    chk("R1 conflict", {31'd0, id0_conflict}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed: identity 3, request on 5 and 2.
    cfg_id = 3'd3; cfg_base = 5'h15; req_in = 8'b0010_0100;
    @(negedge clk);
    chk_idle_int("R2 pending");
    ack_seq(3'd3, 3'd3, 3'd3);             // R3 line 2
    ack_seq(3'd1, 3'd3, 3'd1);             // R5 mismatch, R3 unchanged
    req_in = 8'b0000_0001;
    @(negedge clk);
    chk_idle_int("R2 higher request");
    // R11: identity changed after first pulse, still drives.
    ack_seq(3'd3, 3'd6, 3'd0);
    cfg_id = 3'd3;
    pulse_eoi();                           // R9 clears line 0
    pulse_eoi();                           // R9 clears line 2
    // R10: nothing pending.
    req_in = 8'h00;
    @(negedge clk);
    ack_seq(3'd3, 3'd3, 3'd3);
    // R8: identity zero matches uncascaded address.
    cfg_id = 3'd0; req_in = 8'b1000_0000;
    @(negedge clk);
    ack_seq(3'd0, 3'd0, 3'd0);
    pulse_eoi();
    // R11: address changed to match late does not cause drive.
    cfg_id = 3'd4;
    ack_seq(3'd2, 3'd4, 3'd4);

    for (int k = 0; k < 300; k++) begin
      req_in   = 8'($urandom);
      cfg_base = 5'($urandom);
      cfg_id   = 3'($urandom);
      @(negedge clk);
      chk_idle_int("R2 random");
      if ($urandom % 2) ack_seq(cfg_id, cfg_id, cfg_id);
      else              ack_seq(3'($urandom), cfg_id, 3'($urandom));
      if ($urandom % 3 != 0) pulse_eoi();
    end
    done = 1;
    finish_run();
  end
endmodule